// File: doc/BRIEF.md
# Peripheral Ready Status Tracker

This block reports, for each of four serial peripheral instances, whether the instance can be accessed by software. Each instance has three control inputs: a power-enable bit, a run-mode clock-enable bit and a software-reset bit. A rising power-enable bit, a change of the clock-enable bit in either direction, or a rising software-reset bit counts as a trigger event. A trigger event drops that instance's ready flag.

A small sequencer for each instance then steps through three waits. It waits for power, then for the clock, then for the end of the internal reset. Only after all three waits does it raise the flag again. The power switch, the clock gate and the peripheral's reset logic are outside this block. They are represented by three acknowledge inputs per instance.

Software sees the four flags in a 32-bit status word. The word is read-only, and a write presented at the write port changes nothing.

Top module: `periph_ready_tracker`

## Requirements
- R1: Bit n of `status_o` equals the ready flag of instance n (n = 0..3). Bits 31 down to 4 always read 0.
- R2: While `rst_n` is low and after it is released, every bit of `status_o` is 0 until a sequencer completes.
- R3: A 0-to-1 change of `pwr_en_i[n]` makes bit n read 0 after the next rising clock edge. A 1-to-0 change of that bit has no effect on the flag.
- R4: Any change of `clk_en_i[n]`, rising or falling, makes bit n read 0 after the next rising clock edge.
- R5: A 0-to-1 change of `sw_rst_i[n]` makes bit n read 0 after the next rising clock edge. A 1-to-0 change of that bit has no effect on the flag.
- R6: After a trigger event, while `clk_en_i[n]` stays 1 and all three acknowledges stay 1, bit n reads 0 for three clock edges and reads 1 from the fourth edge after the control change onward.
- R7: Bit n rises only on the edge after `pwr_ack_i[n]`, `clk_ack_i[n]` and `rst_done_i[n]` are all 1. If any of them is 0, bit n stays 0. Losing any of them while ready clears bit n at the next edge.
- R8: A new trigger event during a sequence restarts it from the power wait. Bit n stays 0 throughout and rises on the fourth edge after the last event.
- R9: While `clk_en_i[n]` is 0, bit n reads 0 regardless of the acknowledge inputs.
- R10: A write (`wr_en_i` high with any `wr_data_i`) never alters `status_o`.
- R11: A trigger event or missing acknowledge on one instance leaves the other instances' bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en_i | input | 4 | Power-enable control bit per instance |
| clk_en_i | input | 4 | Run-mode clock-enable control bit per instance |
| sw_rst_i | input | 4 | Software-reset control bit per instance |
| pwr_ack_i | input | 4 | Power domain reports powered, per instance |
| clk_ack_i | input | 4 | Clock gate reports clock running, per instance |
| rst_done_i | input | 4 | Peripheral reports internal reset finished, per instance |
| wr_en_i | input | 1 | Software write strobe to the status word (ignored) |
| wr_data_i | input | 32 | Software write data (ignored) |
| status_o | output | 32 | Read-only status word, bit n = instance n ready |

## Verification
A sequencer stuck in, or skipping, a wait state is visible directly on its bit of `status_o`. Each state decision shows one clock edge later, so a miscounted wait shows up as a flag that rises one edge early or late against the fixed four-edge recovery. A lost edge-detector history shows up in two ways. Either a falling power or reset bit wrongly drops the flag, or a clock-enable toggle fails to drop it. Both appear on the first edge after the control change. Crosstalk between instances shows up as a neighbouring bit moving in the same sample.

// File: rtl/prt_pkg.sv
// Shared types for the peripheral ready status tracker.
package prt_pkg;

    // Recovery sequencer states; the ready flag is 1 only in ST_IDLE_READY.
    typedef enum logic [2:0] {
        ST_NOT_READY  = 3'd0,
        ST_WAIT_POWER = 3'd1,
        ST_WAIT_CLOCK = 3'd2,
        ST_WAIT_RESET = 3'd3,
        ST_IDLE_READY = 3'd4
    } prt_state_e;

endpackage

// File: rtl/prt_edge_detect.sv
// Trigger-event detector for all instances.
// Keeps the previous value of each control bit and flags a rising power-enable,
// any change of clock-enable, or a rising software-reset in the current cycle.
// Assumes the control bits are synchronous to clk.
module prt_edge_detect #(
    parameter int NUM_INST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INST-1:0] pwr_en_i,
    input  logic [NUM_INST-1:0] clk_en_i,
    input  logic [NUM_INST-1:0] sw_rst_i,
    output logic [NUM_INST-1:0] evt_o
);

    logic [NUM_INST-1:0] pwr_q;
    logic [NUM_INST-1:0] cken_q;
    logic [NUM_INST-1:0] srst_q;

    // Capture last-cycle control values; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= '0;
            cken_q <= '0;
            srst_q <= '0;
        end else begin
            pwr_q  <= pwr_en_i;
            cken_q <= clk_en_i;
            srst_q <= sw_rst_i;
        end
    end

    // Combine the three per-instance event kinds.
    always_comb begin
        evt_o = (pwr_en_i & ~pwr_q) | (clk_en_i ^ cken_q) | (sw_rst_i & ~srst_q);
    end

endmodule

// File: rtl/prt_seq.sv
// Per-instance recovery sequencer.
// After a trigger event it waits for power, then clock, then reset completion,
// and raises ready only once all three acknowledges are high together.
// Assumes acknowledges are synchronous and level-held by the domain logic.
module prt_seq
    import prt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clk_en_i,
    input  logic pwr_ack_i,
    input  logic clk_ack_i,
    input  logic rst_done_i,
    output logic ready_o
);

    prt_state_e state_q;
    prt_state_e state_d;
    logic       all_ack;

    // All three domain conditions confirmed.
    always_comb begin
        all_ack = pwr_ack_i & clk_ack_i & rst_done_i;
    end

    // Next-state selection: clock-off and new events override the wait chain.
    always_comb begin
        state_d = state_q;
        if (!clk_en_i) begin
            state_d = ST_NOT_READY;
        end else if (evt_i) begin
            state_d = ST_WAIT_POWER;
        end else begin
            case (state_q)
                ST_NOT_READY:  state_d = ST_WAIT_POWER;
                ST_WAIT_POWER: if (pwr_ack_i) state_d = ST_WAIT_CLOCK;
                ST_WAIT_CLOCK: begin
                    if (!pwr_ack_i)     state_d = ST_WAIT_POWER;
                    else if (clk_ack_i) state_d = ST_WAIT_RESET;
                end
                ST_WAIT_RESET: begin
                    if (!pwr_ack_i)      state_d = ST_WAIT_POWER;
                    else if (!clk_ack_i) state_d = ST_WAIT_CLOCK;
                    else if (rst_done_i) state_d = ST_IDLE_READY;
                end
                ST_IDLE_READY: if (!all_ack) state_d = ST_WAIT_POWER;
                default:       state_d = ST_NOT_READY;
            endcase
        end
    end

    // State register; reset leaves the instance not ready.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NOT_READY;
        else        state_q <= state_d;
    end

    // Ready flag decoded from the settled state.
    always_comb begin
        ready_o = (state_q == ST_IDLE_READY);
    end

    // R3 R4 R5
    evt_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> !ready_o);

    // R9
    clk_off_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_i |=> !ready_o);

    // R7
    rise_needs_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(pwr_ack_i && clk_ack_i && rst_done_i));

    // R7
    ack_loss_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !all_ack) |=> !ready_o);

endmodule

// File: rtl/prt_status_port.sv
// Read-only status word assembly.
// Places instance n's flag at bit n and zero-fills the rest; the write port is
// accepted but never stored. Assumes NUM_INST <= WORD_W.
module prt_status_port #(
    parameter int NUM_INST = 4,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INST-1:0] flags_i,
    input  logic                wr_en_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    output logic [WORD_W-1:0]   status_o
);

    localparam int PAD_W = WORD_W - NUM_INST;

    generate
        if (PAD_W > 0) begin : g_pad
            // Flags in the low bits, constant zero above.
            always_comb begin
                status_o = {{PAD_W{1'b0}}, flags_i};
            end
        end else begin : g_nopad
            // Flags fill the whole word.
            always_comb begin
                status_o = flags_i;
            end
        end
    endgenerate

    // R10
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && ($past(wr_data_i) != $past(status_o)) && $stable(flags_i))
        |-> $stable(status_o));

endmodule

// File: rtl/periph_ready_tracker.sv
// Peripheral ready status tracker, top level.
// Detects per-instance trigger events on the control bits, runs one recovery
// sequencer per instance and presents the flags in a read-only status word.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module periph_ready_tracker #(
    parameter int NUM_INST = 4,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_INST-1:0] pwr_en_i,
    input  logic [NUM_INST-1:0] clk_en_i,
    input  logic [NUM_INST-1:0] sw_rst_i,
    input  logic [NUM_INST-1:0] pwr_ack_i,
    input  logic [NUM_INST-1:0] clk_ack_i,
    input  logic [NUM_INST-1:0] rst_done_i,
    input  logic                wr_en_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    output logic [WORD_W-1:0]   status_o
);

    logic [NUM_INST-1:0] evt;
    logic [NUM_INST-1:0] ready;

    prt_edge_detect #(
        .NUM_INST (NUM_INST)
    ) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en_i (pwr_en_i),
        .clk_en_i (clk_en_i),
        .sw_rst_i (sw_rst_i),
        .evt_o    (evt)
    );

    generate
        for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
            prt_seq seq_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt_i      (evt[g]),
                .clk_en_i   (clk_en_i[g]),
                .pwr_ack_i  (pwr_ack_i[g]),
                .clk_ack_i  (clk_ack_i[g]),
                .rst_done_i (rst_done_i[g]),
                .ready_o    (ready[g])
            );

            // R3
            pwr_rise_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pwr_en_i[g]) |=> !status_o[g]);

            // R4
            cken_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en_i[g] != $past(clk_en_i[g])) |=> !status_o[g]);
        end
    endgenerate

    prt_status_port #(
        .NUM_INST (NUM_INST),
        .WORD_W   (WORD_W)
    ) port_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags_i   (ready),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .status_o  (status_o)
    );

    // R2
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0));

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o >> NUM_INST) == '0);

endmodule

// File: tb/periph_ready_tracker_tb.sv
`timescale 1ns/1ps
module periph_ready_tracker_tb_top;

    localparam int N = 4;
    localparam logic [31:0] ALL = 32'hF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] pwr, cken, srst, pack, cack, rdone;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] status;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    periph_ready_tracker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_en_i   (pwr),
        .clk_en_i   (cken),
        .sw_rst_i   (srst),
        .pwr_ack_i  (pack),
        .clk_ack_i  (cack),
        .rst_done_i (rdone),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .status_o   (status)
    );

    task automatic chk(input string req, input logic [31:0] exp);
        checks++;
        if (status !== exp) begin
            errors++;
            $display("FAIL %s: status=%h expected=%h at %0t", req, status, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // After a trigger at the current negedge: three samples low, fourth high.
    task automatic expect_recover(input string req, input int n);
        logic [31:0] low;
        low = ALL & ~(32'd1 << n);
        for (int k = 1; k <= 3; k++) begin
            step();
            chk(req, low);
        end
        step();
        chk(req, ALL);
    endtask

    initial begin
        rst_n = 1'b0; pwr = '0; cken = '0; srst = '0;
        pack = '0; cack = '0; rdone = '0; wr_en = 1'b0; wr_data = '0;
        step();
        chk("R2 in reset", 32'd0);
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R2 after release", 32'd0);
        // R9: clock enable off, acks high, stays not ready
        pack = '1; cack = '1; rdone = '1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R9 clock off", 32'd0);
        end
        // R6: enable all clocks, four-edge recovery
        cken = '1;
        for (int k = 1; k <= 3; k++) begin
            step();
            chk("R6 bring-up", 32'd0);
        end
        step();
        chk("R6 R1 bring-up", ALL);

        for (int n = 0; n < N; n++) begin
            // R3 rising power bit, R11 others unchanged
            pwr[n] = 1'b1;
            expect_recover("R3 R11", n);
            pwr[n] = 1'b0;
            for (int k = 0; k < 4; k++) begin
                step();
                chk("R3 falling ignored", ALL);
            end
            // R5 rising reset bit
            srst[n] = 1'b1;
            expect_recover("R5 R11", n);
            srst[n] = 1'b0;
            for (int k = 0; k < 4; k++) begin
                step();
                chk("R5 falling ignored", ALL);
            end
            // R4 falling clock enable, R9 stays low
            cken[n] = 1'b0;
            for (int k = 0; k < 5; k++) begin
                step();
                chk("R4 R9 clock off", ALL & ~(32'd1 << n));
            end
            cken[n] = 1'b1;
            expect_recover("R4 rising", n);
            // R8 restart mid-sequence
            pwr[n] = 1'b1;
            step(); chk("R8 first event", ALL & ~(32'd1 << n));
            step(); chk("R8 mid", ALL & ~(32'd1 << n));
            pwr[n] = 1'b0;
            srst[n] = 1'b1;
            expect_recover("R8 restart", n);
            srst[n] = 1'b0;
            step();
            // R7 ack combinations after a reset-bit trigger
            for (int c = 0; c < 8; c++) begin
                pack[n] = c[0]; cack[n] = c[1]; rdone[n] = c[2];
                srst[n] = 1'b1;
                step();
                srst[n] = 1'b0;
                for (int k = 0; k < 6; k++) step();
                chk("R7 ack combo", (c == 7) ? ALL : (ALL & ~(32'd1 << n)));
                pack[n] = 1'b1; cack[n] = 1'b1; rdone[n] = 1'b1;
                for (int k = 0; k < 5; k++) step();
                chk("R7 restore", ALL);
            end
            // R7 ack loss while ready, then regain takes three edges
            rdone[n] = 1'b0;
            step(); chk("R7 loss", ALL & ~(32'd1 << n));
            rdone[n] = 1'b1;
            step(); chk("R7 regain 1", ALL & ~(32'd1 << n));
            step(); chk("R7 regain 2", ALL & ~(32'd1 << n));
            step(); chk("R7 regain 3", ALL);
        end

        // R10 writes ignored, with all ready and with one instance down
        for (int k = 0; k < 16; k++) begin
            wr_en = 1'b1;
            wr_data = 32'h9E3779B1 * (k + 1);
            step();
            chk("R10 write all ready", ALL);
        end
        cken[0] = 1'b0;
        step();
        for (int k = 0; k < 4; k++) begin
            wr_data = 32'hFFFFFFFF;
            step();
            chk("R10 R1 write one down", 32'hE);
        end
        wr_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule